// File: doc/BRIEF.md
# Processor breakpoint and trace unit

This on-chip debug block sits next to a processor core. It watches the retiring program address and the data-access address, and decides when the core must stop and enter emulation mode. There are four programmable address comparators. Each one can be pointed at either program space or data space. An occurrence counter lets a breakpoint pass a chosen number of times before it halts. A single-step mode stops the core after every retired instruction. An active-low external request pin forces a halt from outside.

A small ring of recent program addresses holds the last six retired instructions, so a debugger can see how the core got where it stopped. Once the halt request is raised it stays up until the debugger writes the resume bit. While the core is halted, retire strobes and data strobes have no effect on the trace ring, the counter or the comparators.

All configuration goes through a flat register port with a write strobe and a combinational read.

Top module: `dbg_halt_unit`

## Requirements
- R1: After reset `emu_req_o` is 0. Every readable register reads 0: addresses 0 to 6 and 9, and every trace entry read at address 8.
- R2: The breakpoint address registers sit at addresses 0 to 3. Address 4 holds the enable bits and address 5 the space-select bits, one bit per breakpoint, with bit n belonging to breakpoint n. All of them read back what was written. A read of address 7 returns 0.
- R3: A breakpoint with its enable bit set and its space bit at 0 matches when `retire_i` is high and `pc_i` equals its address. If the counter is zero, `emu_req_o` is 1 from the next clock edge.
- R4: A breakpoint with its space bit at 1 matches only when `dacc_i` is high and `daddr_i` equals its address. A retire at that same address does not match it.
- R5: A breakpoint whose enable bit is 0 never raises `emu_req_o`.
- R6: A write to address 6 sets the single-step bit from bit 0 and loads the occurrence counter from bits 8:1. A match while the counter is nonzero decrements the counter and does not halt. A match while the counter is zero halts. Address 9 reads the counter.
- R7: With the single-step bit set, a retire while not halted raises `emu_req_o` at the next edge.
- R8: When `ext_halt_ni` is held low, `emu_req_o` rises on the third clock edge after the input falls. The input passes through two synchroniser stages first.
- R9: `emu_req_o` stays 1 until a write of 1 to bit 0 of address 7. If a halt source is active in the same cycle as that write, the halt source wins.
- R10: Each retire while not halted stores `pc_i` into a 6-entry circular ring. Writing address 8 selects an index. Reading address 8 returns the entry at that index, where 0 is the newest. An index of 6 or more reads 0.
- R11: While `emu_req_o` is 1, a retire or data access has no effect. It does not write the trace ring, does not match a breakpoint, does not decrement the counter and does not trigger a single-step halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | 16 | Address of the retiring instruction |
| retire_i | input | 1 | Instruction retire strobe |
| daddr_i | input | 16 | Data access address |
| dacc_i | input | 1 | Data access strobe |
| ext_halt_ni | input | 1 | External halt request, active low, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational |
| emu_req_o | output | 1 | Emulation-mode request |

## Verification
The bench runs random sequences of matching and non-matching retires against random counter reloads. A counter that stops one step late, or that halts on a nonzero count, therefore shows up as a halt in the wrong cycle.

It checks the newest-first ordering of the trace ring after more than six writes, so the ring has wrapped. An off-by-one read pointer returns the neighbouring address.

It tries a retire at a data-space breakpoint's address, which must not halt, and issues retires while halted, which must leave the ring and the counter unchanged.

It holds the external pin low across a resume write. A design that let resume beat an active request would drop the halt. Counting edges on the external pin exposes a missing or extra synchroniser stage.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    RA_BP0    = 4'd0,
    RA_BP1    = 4'd1,
    RA_BP2    = 4'd2,
    RA_BP3    = 4'd3,
    RA_EN     = 4'd4,
    RA_SPACE  = 4'd5,
    RA_STEP   = 4'd6,
    RA_RESUME = 4'd7,
    RA_TRACE  = 4'd8,
    RA_CNT    = 4'd9
  } reg_addr_e;
endpackage

// File: rtl/dbg_bp_match.sv
module dbg_bp_match #(
  parameter int AW     = 16,
  parameter int NUM_BP = 4
) (
  input  logic [NUM_BP-1:0][AW-1:0] bp_addr_i,
  input  logic [NUM_BP-1:0]         en_i,
  input  logic [NUM_BP-1:0]         space_i,
  input  logic [AW-1:0]             pc_i,
  input  logic                      retire_i,
  input  logic [AW-1:0]             daddr_i,
  input  logic                      dacc_i,
  output logic                      hit_o
);
  logic [NUM_BP-1:0] hit_vec;

  for (genvar g = 0; g < NUM_BP; g++) begin : g_cmp
    logic prog_hit, data_hit;
    assign prog_hit   = retire_i && (pc_i == bp_addr_i[g]);
    assign data_hit   = dacc_i && (daddr_i == bp_addr_i[g]);
    assign hit_vec[g] = en_i[g] && (space_i[g] ? data_hit : prog_hit);
  end

  // simultaneous hits count as one occurrence
  assign hit_o = |hit_vec;
endmodule

// File: rtl/dbg_trace_ring.sv
module dbg_trace_ring #(
  parameter int AW    = 16,
  parameter int DEPTH = 6,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          freeze_i,
  input  logic [AW-1:0] wdata_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [AW-1:0] rd_data_o
);
  logic [DEPTH-1:0][AW-1:0] mem_q;
  logic [IW-1:0]            wptr_q;
  logic [IW:0]              pos;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q  <= '0;
      wptr_q <= '0;
    end else if (we_i && !freeze_i) begin
      mem_q[wptr_q] <= wdata_i;
      wptr_q <= (wptr_q == IW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
    end
  end

  // newest entry sits one slot behind the write pointer
  always_comb begin
    pos = (IW+1)'(wptr_q) + (IW+1)'(DEPTH-1) - (IW+1)'(rd_idx_i);
    if (pos >= (IW+1)'(DEPTH)) pos = pos - (IW+1)'(DEPTH);
    rd_data_o = (rd_idx_i < IW'(DEPTH)) ? mem_q[pos[IW-1:0]] : '0;
  end

  assert_frozen_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> wptr_q == $past(wptr_q));
  assert_wptr_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wptr_q < IW'(DEPTH));
endmodule

// File: rtl/dbg_halt_unit.sv
module dbg_halt_unit
  import dbg_pkg::*;
#(
  parameter int AW       = 16,
  parameter int NUM_BP   = 4,
  parameter int CNT_W    = 8,
  parameter int TR_DEPTH = 6,
  localparam int TIW     = $clog2(TR_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     pc_i,
  input  logic              retire_i,
  input  logic [AW-1:0]     daddr_i,
  input  logic              dacc_i,
  input  logic              ext_halt_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [AW-1:0]     reg_wdata_i,
  output logic [AW-1:0]     reg_rdata_o,
  output logic              emu_req_o
);
  logic [NUM_BP-1:0][AW-1:0] bp_q;
  logic [NUM_BP-1:0]         en_q, space_q;
  logic                      step_q, halt_q;
  logic [CNT_W-1:0]          reload_q, cnt_q;
  logic [TIW-1:0]            tidx_q;
  logic [1:0]                sync_q;
  logic                      hit_raw, bp_hit, halt_set, resume, step_wr;
  logic [AW-1:0]             tr_data;

  dbg_bp_match #(.AW(AW), .NUM_BP(NUM_BP)) u_match (
    .bp_addr_i (bp_q),
    .en_i      (en_q),
    .space_i   (space_q),
    .pc_i      (pc_i),
    .retire_i  (retire_i),
    .daddr_i   (daddr_i),
    .dacc_i    (dacc_i),
    .hit_o     (hit_raw)
  );

  dbg_trace_ring #(.AW(AW), .DEPTH(TR_DEPTH)) u_trace (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (retire_i),
    .freeze_i  (halt_q),
    .wdata_i   (pc_i),
    .rd_idx_i  (tidx_q),
    .rd_data_o (tr_data)
  );

  assign step_wr  = reg_we_i && (reg_addr_i == RA_STEP);
  assign resume   = reg_we_i && (reg_addr_i == RA_RESUME) && reg_wdata_i[0];
  assign bp_hit   = hit_raw && !halt_q;
  assign halt_set = !sync_q[1] || (bp_hit && cnt_q == '0)
                 || (step_q && retire_i && !halt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bp_q     <= '0;
      en_q     <= '0;
      space_q  <= '0;
      step_q   <= 1'b0;
      reload_q <= '0;
      tidx_q   <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        RA_EN:    en_q    <= reg_wdata_i[NUM_BP-1:0];
        RA_SPACE: space_q <= reg_wdata_i[NUM_BP-1:0];
        RA_STEP: begin
          step_q   <= reg_wdata_i[0];
          reload_q <= reg_wdata_i[CNT_W:1];
        end
        RA_TRACE: tidx_q  <= (reg_wdata_i < AW'(TR_DEPTH)) ? reg_wdata_i[TIW-1:0]
                                                          : TIW'(TR_DEPTH);
        default: if (reg_addr_i < REG_AW'(NUM_BP)) bp_q[reg_addr_i[1:0]] <= reg_wdata_i;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sync_q <= 2'b11;
      halt_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], ext_halt_ni};
      if (step_wr)                   cnt_q <= reg_wdata_i[CNT_W:1];
      else if (bp_hit && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
      if (halt_set)    halt_q <= 1'b1;
      else if (resume) halt_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      RA_BP0, RA_BP1, RA_BP2, RA_BP3: reg_rdata_o = bp_q[reg_addr_i[1:0]];
      RA_EN:    reg_rdata_o = AW'(en_q);
      RA_SPACE: reg_rdata_o = AW'(space_q);
      RA_STEP:  reg_rdata_o = AW'({reload_q, step_q});
      RA_TRACE: reg_rdata_o = tr_data;
      RA_CNT:   reg_rdata_o = AW'(cnt_q);
      default:  reg_rdata_o = '0;
    endcase
  end

  assign emu_req_o = halt_q;

  assert_ext_halt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_q[1] |=> halt_q);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_q && !resume |=> halt_q);
  assert_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q && retire_i && !halt_q |=> halt_q);
  assert_cnt_dec_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bp_hit && cnt_q != 0 && !step_wr |=> cnt_q == $past(cnt_q) - 1'b1);
  assert_halted_cnt_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_q && !step_wr |=> $stable(cnt_q));
endmodule

// File: tb/dbg_halt_unit_tb.sv
`timescale 1ns/1ps
module dbg_halt_unit_tb;
  logic        clk = 0, rst_n = 0;
  logic [15:0] pc = 0, daddr = 0, wdata = 0;
  logic        retire = 0, dacc = 0, ext_n = 1, we = 0;
  logic [3:0]  addr = 0;
  logic [15:0] rdata;
  logic        emu;
  int total = 0, bad = 0;
  logic [15:0] tr_m [6];

  always #2.5 clk = ~clk;

  dbg_halt_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pc_i(pc), .retire_i(retire),
    .daddr_i(daddr), .dacc_i(dacc), .ext_halt_ni(ext_n),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .emu_req_o(emu)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    we = 1; addr = a; wdata = d; tick(); we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] v);
    addr = a; #1; v = rdata;
  endtask

  function automatic logic [15:0] tr_exp(int i);
    return (i < 6) ? tr_m[i] : 16'h0;
  endfunction

  task automatic ret(logic [15:0] p);
    if (!emu) begin
      for (int k = 5; k > 0; k--) tr_m[k] = tr_m[k-1];
      tr_m[0] = p;
    end
    retire = 1; pc = p; tick(); retire = 0;
  endtask

  task automatic tr_rd(int i, output logic [15:0] v);
    wr(4'd8, 16'(i)); rd(4'd8, v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired act=running exp=done");
    bad++; total++;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] bpv [4];
    int cnt_m;
    bit exp_h;
    void'($urandom(32'h1357));
    for (int k = 0; k < 6; k++) tr_m[k] = 0;
    #12 rst_n = 1; tick();

    // R1 reset state
    chk("R1 emu", emu, 0);
    for (int a = 0; a < 10; a++) begin
      if (a == 8) continue;
      rd(4'(a), v); chk("R1 reg", v, 0);
    end
    for (int i = 0; i < 6; i++) begin tr_rd(i, v); chk("R1 trace", v, 0); end

    // R2 readback
    for (int i = 0; i < 4; i++) begin bpv[i] = 16'($urandom) | 16'h0100; wr(4'(i), bpv[i]); end
    wr(4'd4, 16'h5); wr(4'd5, 16'hA);
    for (int i = 0; i < 4; i++) begin rd(4'(i), v); chk("R2 bp", v, bpv[i]); end
    rd(4'd4, v); chk("R2 en", v, 16'h5);
    rd(4'd5, v); chk("R2 space", v, 16'hA);
    rd(4'd7, v); chk("R2 resume rd", v, 0);
    wr(4'd5, 16'h0);

    // R5 disabled breakpoint
    wr(4'd4, 16'h0);
    ret(bpv[0]); chk("R5 disabled", emu, 0);

    // R3 program breakpoint
    wr(4'd4, 16'h1);
    ret(bpv[0] ^ 16'h1); chk("R3 miss", emu, 0);
    ret(bpv[0]); chk("R3 hit", emu, 1);
    tr_rd(0, v); chk("R10 halting pc stored", v, bpv[0]);
    wr(4'd7, 16'h1); chk("R9 resume", emu, 0);

    // R4 data breakpoint
    wr(4'd4, 16'h2); wr(4'd5, 16'h2);
    ret(bpv[1]); chk("R4 pc ignored", emu, 0);
    daddr = bpv[1] ^ 16'h4; dacc = 1; tick(); dacc = 0; chk("R4 miss", emu, 0);
    daddr = bpv[1]; dacc = 1; tick(); dacc = 0; chk("R4 hit", emu, 1);
    wr(4'd7, 16'h1);

    // R6 counter
    wr(4'd6, 16'(3 << 1));
    rd(4'd9, v); chk("R6 load", v, 3);
    for (int n = 2; n >= 0; n--) begin
      dacc = 1; tick(); dacc = 0;
      chk("R6 no halt", emu, 0); rd(4'd9, v); chk("R6 dec", v, 16'(n));
    end
    dacc = 1; tick(); dacc = 0; chk("R6 halt at zero", emu, 1);
    // R11 halted: counter and match untouched
    wr(4'd6, 16'(2 << 1)); wr(4'd7, 16'h0); chk("R9 bit0 clear keeps", emu, 1);
    dacc = 1; tick(); dacc = 0; rd(4'd9, v); chk("R11 cnt frozen", v, 2);
    wr(4'd6, 16'h0); wr(4'd7, 16'h1); wr(4'd4, 16'h0);

    // R7 single step
    wr(4'd6, 16'h1);
    ret(16'h0055); chk("R7 step", emu, 1);
    ret(16'h0077); tr_rd(0, v); chk("R11 trace frozen", v, 16'h0055);
    wr(4'd6, 16'h0); wr(4'd7, 16'h1); chk("R9 resume", emu, 0);

    // R8 external request, R9 concurrency
    ext_n = 0; tick(); tick(); chk("R8 two stages", emu, 0);
    tick(); chk("R8 halt", emu, 1);
    wr(4'd7, 16'h1); chk("R9 set wins", emu, 1);
    ext_n = 1; tick(); tick();
    wr(4'd7, 16'h1); chk("R9 released", emu, 0);

    // R10 random trace fill with wrap
    for (int it = 0; it < 40; it++) ret(16'($urandom));
    for (int i = 0; i < 7; i++) begin tr_rd(i, v); chk("R10 order", v, tr_exp(i)); end

    // R6/R3 random counted breakpoints
    wr(4'd0, 16'h0010); wr(4'd5, 16'h0); wr(4'd4, 16'h1);
    for (int it = 0; it < 60; it++) begin
      cnt_m = $urandom % 4;
      wr(4'd6, 16'(cnt_m << 1));
      for (int s = 0; s < 50; s++) begin
        pc = 16'h0010 + 16'($urandom % 3);
        exp_h = 0;
        if (pc == 16'h0010) begin
          if (cnt_m == 0) exp_h = 1; else cnt_m--;
        end
        ret(pc);
        chk("R6 random halt", emu, exp_h);
        if (exp_h) begin wr(4'd7, 16'h1); break; end
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule